// File: doc/BRIEF.md
# Serial Flash Write-Enable Controller

This block is the slave-side command front end of a small serial flash. It watches the SPI pins (chip enable, serial clock, serial data in) and samples one command byte, most significant bit first, on each rising serial clock edge while chip enable is low. Both clock polarities used by SPI mode 0 (clock idles low) and mode 3 (clock idles high) are accepted. A command does not act when its last bit arrives. It acts when chip enable returns high, and only if the frame carried the bit count that the command requires.

The block holds the write-enable latch, the auto-increment flag and a one-shot arm that opens the status register for a single write. It returns the status byte on the serial data output when the read-status command is issued. It grants program/erase requests from a downstream engine only while the write-enable latch is set. The engine reports completion back, and that completion clears the latch. The serial pins are assumed to be already synchronous to the system clock, which runs at least eight times faster than the serial clock.

Top module: `sflash_wel_ctl`

## Requirements
- R1: After reset the write-enable latch, the auto-increment flag, the arm and the writable status bits are all 0. `wr_allow` is 0 and `spi_so_en` is 0.
- R2: Opcode 0x06 in an 8-bit frame sets the write-enable latch when chip enable rises. The latch is still 0 after the eighth clock while chip enable stays low.
- R3: Opcode 0x04 in an 8-bit frame clears both the write-enable latch and the auto-increment flag.
- R4: A one-cycle `pe_req` pulse gives a one-cycle `pe_grant` in the next cycle only if the latch was 1 in the cycle of the request. A `pe_done` pulse clears the latch.
- R5: An `aai_set` pulse sets the auto-increment flag only while the latch is 1.
- R6: If a frame for opcode 0x06, 0x04 or 0x50 ends after a bit count other than 8, it is aborted. The frame also aborts if it ends before 8 bits. An aborted frame changes nothing, and the arm is kept.
- R7: Opcode 0x50 in an 8-bit frame sets the arm. If the next executed command is opcode 0x01 in a 16-bit frame, the second byte writes status bits 7 and 5..2. That write also clears the latch and uses up the arm.
- R8: Any other executed command discards the arm, and this includes 0x06 and 0x05. An unarmed 0x01 frame leaves the status register unchanged.
- R9: The status byte is {bit7 written, bit6 auto-increment, bits5..2 written, bit1 latch, bit0 = 0}. Opcode 0x05 drives this byte on SO, MSB first, changing on falling clock edges. The first bit follows the falling edge after the eighth rising edge, and the byte repeats for as long as the clock runs.
- R10: `spi_so_en` is 0 outside the data phase of the read-status command, which includes during 0x06 and 0x04 frames.
- R11: Every command gives the same result in mode 3 (clock idles high) as in mode 0.
- R12: When a command executes in the same cycle as an engine event, the command's effect wins. A `pe_req` in that cycle is judged on the latch value from before the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Chip enable, active low |
| spi_sck | input | 1 | Serial clock |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out |
| spi_so_en | output | 1 | Output enable for SO (0 = high impedance) |
| pe_req | input | 1 | Program/erase request pulse from the engine |
| pe_grant | output | 1 | Request accepted pulse |
| pe_done | input | 1 | Program/erase completed pulse |
| aai_set | input | 1 | Engine starts an auto-increment sequence |
| wr_allow | output | 1 | Write permission (the write-enable latch) |
| status | output | 8 | Current status byte |

## Verification
A command that executes when chip enable rises can land in the same system cycle as an engine pulse on `pe_req`, `pe_done` or `aai_set`. The bench raises chip enable and pulses the engine input on the same clock edge. It then judges the outcome through `pe_grant`, `wr_allow` and a later status read. The cases are a disable against a request, an enable against a completion, and a disable against an auto-increment start. In each case the expected winner follows the priority stated in R12.

// File: rtl/sfw_pkg.sv
// Shared opcodes and status-byte layout for the serial flash write-enable controller.
// Assumes one-byte opcodes and an 8-bit status register.
package sfw_pkg;
    localparam int unsigned OP_W       = 8;
    localparam logic [7:0]  OP_WREN    = 8'h06;
    localparam logic [7:0]  OP_WRDI    = 8'h04;
    localparam logic [7:0]  OP_EWSR    = 8'h50;
    localparam logic [7:0]  OP_WRSR    = 8'h01;
    localparam logic [7:0]  OP_RDSR    = 8'h05;
    localparam int unsigned BIT_WEL    = 1;
    localparam int unsigned BIT_AAI    = 6;
    localparam logic [7:0]  WR_MASK    = 8'hBC;
    localparam int unsigned ONE_BYTE   = OP_W;
    localparam int unsigned TWO_BYTE   = 2 * OP_W;
endpackage

// File: rtl/sfw_frame_rx.sv
// Frame receiver: detects serial clock and chip-enable edges on the system clock,
// counts bits, latches the opcode and the last received byte, and flags a valid
// command when chip enable rises after the bit count the opcode needs.
// Assumes spi_* inputs are synchronous to clk and the serial clock is much slower.
module sfw_frame_rx
    import sfw_pkg::*;
#(
    parameter int unsigned CNT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sck_i,
    input  logic              si_i,
    output logic              cmd_valid_o,
    output logic [OP_W-1:0]   op_o,
    output logic [OP_W-1:0]   data_o,
    output logic              sck_fall_o,
    output logic              rd_phase_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(ONE_BYTE);
    localparam logic [CNT_W-1:0] CNT_TWO = CNT_W'(TWO_BYTE);

    logic              sck_q, cs_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [OP_W-1:0]   sr_q, op_q;
    logic              sck_rise, cs_rise, len_ok;

    assign sck_rise   = ~cs_n_i & sck_i & ~sck_q;
    assign sck_fall_o = ~cs_n_i & ~sck_i & sck_q;
    assign cs_rise    = cs_n_i & ~cs_q;

    // Decide whether the bit count matches the latched opcode's length.
    always_comb begin
        if (cnt_q < CNT_ONE) len_ok = 1'b0;
        else begin
            unique case (op_q)
                OP_WREN, OP_WRDI, OP_EWSR: len_ok = (cnt_q == CNT_ONE);
                OP_WRSR:                   len_ok = (cnt_q == CNT_TWO);
                default:                   len_ok = 1'b1;
            endcase
        end
    end

    assign cmd_valid_o = cs_rise & len_ok;
    assign op_o        = op_q;
    assign data_o      = sr_q;
    assign rd_phase_o  = ~cs_n_i & (cnt_q >= CNT_ONE) & (op_q == OP_RDSR);

    // Track pin history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck_i;
            cs_q  <= cs_n_i;
        end
    end

    // Count bits and shift data in on rising serial clock edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sr_q  <= '0;
            op_q  <= '0;
        end else if (cs_n_i) begin
            cnt_q <= '0;
        end else if (sck_rise) begin
            sr_q <= {sr_q[OP_W-2:0], si_i};
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_ONE - 1'b1) op_q <= {sr_q[OP_W-2:0], si_i};
        end
    end

    // R6
    short_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_i && !cs_q && cnt_q < CNT_ONE) |-> !cmd_valid_o);
endmodule

// File: rtl/sfw_flag_ctrl.sv
// Flag controller: holds the write-enable latch, auto-increment flag, status-write
// arm and the writable status bits. Executes commands from the frame receiver and
// events from the program/erase engine; a command overrides an event in the same cycle.
// Assumes cmd_valid_i is a single-cycle pulse.
module sfw_flag_ctrl
    import sfw_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid_i,
    input  logic [OP_W-1:0] op_i,
    input  logic [OP_W-1:0] data_i,
    input  logic            pe_req_i,
    input  logic            pe_done_i,
    input  logic            aai_set_i,
    output logic            pe_grant_o,
    output logic            wel_o,
    output logic [7:0]      status_o
);
    logic       wel_q, aai_q, arm_q, grant_q;
    logic [7:0] prot_q;

    // Status byte assembly: written bits, auto-increment flag and latch.
    always_comb begin
        status_o          = prot_q & WR_MASK;
        status_o[BIT_WEL] = wel_q;
        status_o[BIT_AAI] = aai_q;
    end

    assign wel_o      = wel_q;
    assign pe_grant_o = grant_q;

    // Apply engine events first, then let an executed command override them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_q   <= 1'b0;
            aai_q   <= 1'b0;
            arm_q   <= 1'b0;
            grant_q <= 1'b0;
            prot_q  <= '0;
        end else begin
            grant_q <= pe_req_i & wel_q;
            if (pe_done_i) wel_q <= 1'b0;
            if (aai_set_i && wel_q) aai_q <= 1'b1;
            if (cmd_valid_i) begin
                arm_q <= (op_i == OP_EWSR);
                unique case (op_i)
                    OP_WREN: wel_q <= 1'b1;
                    OP_WRDI: begin
                        wel_q <= 1'b0;
                        aai_q <= 1'b0;
                    end
                    OP_WRSR: if (arm_q) begin
                        prot_q <= data_i & WR_MASK;
                        wel_q  <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2
    wren_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && op_i == OP_WREN) |=> wel_q);
    // R3
    wrdi_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && op_i == OP_WRDI) |=> (!wel_q && !aai_q));
    // R4
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pe_grant_o |-> ($past(pe_req_i) && $past(wel_q)));
    // R2
    wel_rise_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel_q) |-> $past(cmd_valid_i));
    // R7
    prot_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prot_q) |-> $past(arm_q));
endmodule

// File: rtl/sfw_status_tx.sv
// Status transmitter: during the read-status data phase, loads the status byte and
// shifts it out MSB first on each falling serial clock edge, repeating every 8 bits.
// Assumes sck_fall_i is already qualified by chip enable.
module sfw_status_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n_i,
    input  logic       sck_fall_i,
    input  logic       rd_phase_i,
    input  logic [7:0] status_i,
    output logic       so_o,
    output logic       so_en_o
);
    logic [7:0] sh_q;
    logic [2:0] idx_q;
    logic       en_q;

    assign so_o    = sh_q[7];
    assign so_en_o = en_q;

    // Load or shift the outgoing byte on falling edges of the read data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            idx_q <= '0;
            en_q  <= 1'b0;
        end else if (cs_n_i) begin
            idx_q <= '0;
            en_q  <= 1'b0;
        end else if (sck_fall_i && rd_phase_i) begin
            sh_q  <= (idx_q == 3'd0) ? status_i : {sh_q[6:0], 1'b0};
            idx_q <= idx_q + 1'b1;
            en_q  <= 1'b1;
        end
    end

    // R10
    so_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_i && $past(cs_n_i)) |-> !so_en_o);
    // R9
    so_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(so_en_o) |-> $past(rd_phase_i));
endmodule

// File: rtl/sflash_wel_ctl.sv
// Top of the serial flash write-enable controller: frame receiver, flag controller
// and status transmitter. Assumes SPI pins synchronous to clk.
module sflash_wel_ctl #(
    parameter int unsigned BIT_CNT_W = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_cs_n,
    input  logic       spi_sck,
    input  logic       spi_si,
    output logic       spi_so,
    output logic       spi_so_en,
    input  logic       pe_req,
    output logic       pe_grant,
    input  logic       pe_done,
    input  logic       aai_set,
    output logic       wr_allow,
    output logic [7:0] status
);
    logic       cmd_valid, sck_fall, rd_phase;
    logic [7:0] op, data;

    sfw_frame_rx #(.CNT_W(BIT_CNT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .cs_n_i(spi_cs_n), .sck_i(spi_sck), .si_i(spi_si),
        .cmd_valid_o(cmd_valid), .op_o(op), .data_o(data),
        .sck_fall_o(sck_fall), .rd_phase_o(rd_phase)
    );

    sfw_flag_ctrl u_flags (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .op_i(op), .data_i(data),
        .pe_req_i(pe_req), .pe_done_i(pe_done), .aai_set_i(aai_set),
        .pe_grant_o(pe_grant), .wel_o(wr_allow), .status_o(status)
    );

    sfw_status_tx u_tx (
        .clk(clk), .rst_n(rst_n), .cs_n_i(spi_cs_n), .sck_fall_i(sck_fall),
        .rd_phase_i(rd_phase), .status_i(status), .so_o(spi_so), .so_en_o(spi_so_en)
    );
endmodule

// File: tb/sflash_wel_ctl_tb.sv
module sflash_wel_ctl_tb;
    localparam int HALF = 4;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_cs_n = 1'b1, spi_sck = 1'b0, spi_si = 1'b0;
    logic pe_req = 1'b0, pe_done = 1'b0, aai_set = 1'b0;
    logic spi_so, spi_so_en, pe_grant, wr_allow;
    logic [7:0] status;

    int n_cmp = 0, n_bad = 0, oe_err = 0;
    bit in_read = 1'b0;
    logic [7:0] exp_v[$];
    string      exp_t[$];
    logic [7:0] got_v[$];
    logic       side_grant;

    always #2.5 clk = ~clk;

    sflash_wel_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_si(spi_si),
        .spi_so(spi_so), .spi_so_en(spi_so_en), .pe_req(pe_req), .pe_grant(pe_grant),
        .pe_done(pe_done), .aai_set(aai_set), .wr_allow(wr_allow), .status(status)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: compare read results against expectations in order.
    always @(negedge clk) begin
        while (exp_v.size() > 0 && got_v.size() > 0) begin
            logic [7:0] e, g;
            string t;
            e = exp_v.pop_front(); t = exp_t.pop_front(); g = got_v.pop_front();
            chk(g === e, t, {8'h0, g}, {8'h0, e});
        end
        if (spi_so_en && !in_read) oe_err++;
    end

    // side: 0 none, 1 pe_done, 2 aai_set, 3 pe_req, 4 check latch still 0 before cs rise
    task automatic frame(input logic [7:0] op, input logic [7:0] b1, input int nb,
                         input bit m3, input int side, output logic [23:0] rd);
        rd = '0;
        @(negedge clk); spi_sck = m3;
        repeat (2) @(negedge clk);
        in_read = (op == 8'h05);
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            if (m3) spi_sck = 1'b0;
            spi_si = (i < 8) ? op[7-i] : (i < 16) ? b1[15-i] : 1'b0;
            repeat (HALF) @(negedge clk);
            if (i >= 8) rd = {rd[22:0], spi_so};
            spi_sck = 1'b1;
            repeat (HALF) @(negedge clk);
            if (!m3) spi_sck = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        if (side == 4) chk(wr_allow == 1'b0, "R2 latch before cs rise", {15'h0, wr_allow}, 16'h0);
        spi_cs_n = 1'b1;
        pe_done = (side == 1); aai_set = (side == 2); pe_req = (side == 3);
        @(negedge clk);
        pe_done = 1'b0; aai_set = 1'b0; pe_req = 1'b0;
        side_grant = pe_grant;
        repeat (3) @(negedge clk);
        in_read = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] op, input int nb, input bit m3, input int side);
        logic [23:0] d;
        frame(op, 8'h00, nb, m3, side, d);
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [23:0] d;
        frame(8'h01, v, 16, 1'b0, 0, d);
    endtask

    task automatic read_sts(input bit m3, input string tag, input logic [7:0] e, input bit twice);
        logic [23:0] d;
        exp_v.push_back(e); exp_t.push_back(tag);
        if (twice) begin
            exp_v.push_back(e); exp_t.push_back({tag, " repeat"});
            frame(8'h05, 8'h00, 24, m3, 0, d);
            got_v.push_back(d[15:8]); got_v.push_back(d[7:0]);
        end else begin
            frame(8'h05, 8'h00, 16, m3, 0, d);
            got_v.push_back(d[7:0]);
        end
    endtask

    task automatic pulse(input int which, output logic g);
        @(negedge clk);
        pe_req = (which == 0); pe_done = (which == 1); aai_set = (which == 2);
        @(negedge clk);
        pe_req = 1'b0; pe_done = 1'b0; aai_set = 1'b0;
        g = pe_grant;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++; n_cmp++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic g;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(wr_allow == 0 && spi_so_en == 0 && status == 8'h00, "R1 reset state",
            {6'h0, wr_allow, spi_so_en, status}, 16'h0);
        read_sts(0, "R1 R9 reset status", 8'h00, 0);

        cmd(8'h06, 8, 0, 4);
        chk(wr_allow == 1'b1, "R2 latch after enable", {15'h0, wr_allow}, 16'h1);
        chk(status == 8'h02, "R9 status port", {8'h0, status}, 16'h02);
        read_sts(0, "R2 status", 8'h02, 0);

        pulse(0, g); chk(g == 1'b1, "R4 grant with latch", {15'h0, g}, 16'h1);
        pulse(1, g); chk(wr_allow == 1'b0, "R4 done clears latch", {15'h0, wr_allow}, 16'h0);
        pulse(0, g); chk(g == 1'b0, "R4 refused without latch", {15'h0, g}, 16'h0);

        pulse(2, g); read_sts(0, "R5 aai ignored without latch", 8'h00, 0);
        cmd(8'h06, 8, 0, 0); pulse(2, g);
        read_sts(0, "R5 aai set", 8'h42, 0);
        cmd(8'h04, 8, 0, 0);
        read_sts(0, "R3 disable clears both", 8'h00, 0);

        cmd(8'h06, 7, 0, 0); read_sts(0, "R6 short enable aborted", 8'h00, 0);
        cmd(8'h06, 9, 0, 0); read_sts(0, "R6 long enable aborted", 8'h00, 0);
        cmd(8'h06, 8, 0, 0); cmd(8'h04, 5, 0, 0);
        read_sts(0, "R6 short disable aborted", 8'h02, 0);

        cmd(8'h50, 8, 0, 0); cmd(8'h06, 7, 0, 0); wrsr(8'hFF);
        read_sts(0, "R7 armed write through abort", 8'hBC, 0);
        chk(wr_allow == 1'b0, "R7 write clears latch", {15'h0, wr_allow}, 16'h0);

        cmd(8'h06, 8, 0, 0); cmd(8'h50, 8, 0, 0); cmd(8'h06, 8, 0, 0); wrsr(8'h00);
        read_sts(0, "R8 arm lost after other command", 8'hBE, 0);
        wrsr(8'h00);
        read_sts(0, "R8 unarmed write ignored", 8'hBE, 0);
        cmd(8'h50, 8, 0, 0); wrsr(8'h84); wrsr(8'h00);
        read_sts(0, "R7 arm used once", 8'h84, 0);

        cmd(8'h06, 8, 1, 0);
        read_sts(1, "R11 R9 mode3 enable and repeat", 8'h86, 1);
        cmd(8'h04, 8, 1, 0);
        read_sts(1, "R11 mode3 disable", 8'h84, 0);

        cmd(8'h06, 8, 0, 0);
        cmd(8'h04, 8, 0, 3);
        chk(side_grant == 1'b1, "R12 request judged on old latch", {15'h0, side_grant}, 16'h1);
        chk(wr_allow == 1'b0, "R12 disable with request", {15'h0, wr_allow}, 16'h0);
        cmd(8'h06, 8, 0, 1);
        chk(wr_allow == 1'b1, "R12 enable wins over done", {15'h0, wr_allow}, 16'h1);
        cmd(8'h04, 8, 0, 2);
        read_sts(0, "R12 disable wins over aai start", 8'h84, 0);

        repeat (10) @(negedge clk);
        chk(oe_err == 0, "R10 SO enable outside read", oe_err[15:0], 16'h0);
        chk(exp_v.size() == 0, "scoreboard drained", 16'(exp_v.size()), 16'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule